// File: doc/BRIEF.md
# Single-Bit Delta-Sigma Output Modulator

This block turns a 10-bit output code into a single-bit pulse-density stream. After an external RC low-pass filter, the stream becomes an analog level. The code is read from the top ten bits of a 16-bit left-justified value word; the six bits below it play no part. A first-order accumulator adds the effective code on every enabled cycle. Its carry becomes the next output bit, and its low ten bits keep the residue. Because the carry works this way, the ones are spread through the period rather than grouped into one pulse, and any 1024 consecutive enabled cycles hold exactly as many ones as the effective code.

A polarity input selects how the code is used. With polarity low the code is used as it is. With polarity high the block uses the code's bitwise inverse, so that a large code drives the filtered level towards zero.

A soft-disable input stops the modulation. While it is set, the output rests at the level of the polarity input and the residue is frozen. A modulator enable strobe sets the update rate, nominally around 2.1 MHz, derived from the faster system clock. A quad converter uses four copies of the block.

Top module: `dsm_bit_driver`

## Requirements
- R1: The code is `valueWord[15:6]`. Bits `valueWord[5:0]` have no effect on the output stream.
- R2: With polarity 0 and soft-disable 0, the effective code equals the code. Any 1024 consecutive enabled cycles produce exactly that many ones.
- R3: With polarity 1 and soft-disable 0, the effective code is the bitwise inverse of the code (1023 minus the code). Any 1024 consecutive enabled cycles produce exactly that many ones.
- R4: While soft-disable is 1, the output equals the polarity input from the next clock onward, and the residue is held. When soft-disable is released, modulation resumes from the held residue.
- R5: With soft-disable 0 and the modulator enable 0, both the output and the residue hold their values.
- R6: Reset (active low, asynchronous) clears the output and the residue to 0.
- R7: An effective code of 0 gives a constant low output on every enabled cycle.
- R8: For an effective code below 512, two consecutive enabled cycles never both produce a one.
- R9: On each enabled cycle, the output becomes 1 exactly when residue plus effective code is at least 1024, and the residue becomes that sum modulo 1024. A new code is used on the next enabled cycle and does not clear the residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valueWord | input | 16 | Left-justified value word; code in bits 15:6 |
| polarity | input | 1 | 0: code used directly; 1: code inverted |
| softDisable | input | 1 | 1: stop modulating and rest the output at the polarity level |
| modEn | input | 1 | Modulator update strobe, one clock wide per step |
| bitOut | output | 1 | Registered pulse-density output bit |

## Verification
The assertions assume that the code, polarity, soft-disable and enable inputs are stable at each rising clock edge. They also assume that reset is released synchronously to the clock, so that the value an input had before an edge decides that edge's step. The bench changes every input only at the falling clock edge and releases reset there as well. Its reference model reads the same sampled values at each rising edge, so the stimulus never changes a value while it is being sampled.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Strobes handed from the control decode to the datapath each clock.
  typedef struct packed {
    logic advance;     // take one modulator step this cycle
    logic forceOut;    // drive the output to a static level
    logic forceLevel;  // static level used while forceOut is set
    logic invert;      // use the inverted code
  } dsmStrobe_t;

endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
(
  input  logic       polarity,
  input  logic       softDisable,
  input  logic       modEn,
  output dsmStrobe_t strobe
);

  // Soft-disable takes priority over stepping; with neither active, everything holds.
  always_comb begin
    strobe            = '0;
    strobe.invert     = polarity;
    strobe.forceLevel = polarity;
    if (softDisable) begin
      strobe.forceOut = 1'b1;
    end else if (modEn) begin
      strobe.advance = 1'b1;
    end
  end

endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  dsmStrobe_t        strobe,
  output logic              bitOut
);

  localparam int SUM_W = CODE_W + 1;

  logic [CODE_W-1:0] residue;
  logic [CODE_W-1:0] effCode;
  logic [SUM_W-1:0]  sum;
  logic              outReg;

  assign effCode = strobe.invert ? ~code : code;
  assign sum     = {1'b0, residue} + {1'b0, effCode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      residue <= '0;
      outReg  <= 1'b0;
    end else if (strobe.forceOut) begin
      outReg <= strobe.forceLevel;
    end else if (strobe.advance) begin
      residue <= sum[CODE_W-1:0];
      outReg  <= sum[SUM_W-1];
    end
  end

  assign bitOut = outReg;

endmodule

// File: rtl/dsm_bit_driver.sv
module dsm_bit_driver
  import dsm_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int CODE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] valueWord,
  input  logic             polarity,
  input  logic             softDisable,
  input  logic             modEn,
  output logic             bitOut
);

  localparam int CODE_LSB = VAL_W - CODE_W;

  logic [CODE_W-1:0] code;
  dsmStrobe_t        strobe;

  assign code = valueWord[VAL_W-1 -: CODE_W];

  // Bits below the code carry no meaning for the modulator.
  generate
    if (CODE_LSB > 0) begin : g_lowBits
      logic unusedLow;
      assign unusedLow = ^valueWord[CODE_LSB-1:0];
    end
  endgenerate

  dsm_ctrl ctrl_i (
    .polarity   (polarity),
    .softDisable(softDisable),
    .modEn      (modEn),
    .strobe     (strobe)
  );

  dsm_datapath #(.CODE_W(CODE_W)) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code),
    .strobe(strobe),
    .bitOut(bitOut)
  );

endmodule

// File: rtl/dsm_bit_driver_chk.sv
module dsm_bit_driver_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] codeIn,
  input logic              polarity,
  input logic              softDisable,
  input logic              modEn,
  input logic              bitOut
);

  logic [CODE_W-1:0] effCode;
  logic              stepNow;
  logic              effLow;

  assign effCode = polarity ? ~codeIn : codeIn;
  assign stepNow = rst_n && modEn && !softDisable;
  assign effLow  = !effCode[CODE_W-1];

  AST_DISABLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    softDisable |=> (bitOut == $past(polarity))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!softDisable && !modEn) |=> $stable(bitOut)); // R5

  AST_ZERO_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stepNow && effCode == '0) |=> !bitOut); // R7

  AST_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (stepNow && effLow && bitOut && $past(stepNow && effLow)) |=> !bitOut); // R8

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !bitOut); // R6

endmodule

bind dsm_bit_driver dsm_bit_driver_chk #(.CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .codeIn     (code),
  .polarity   (polarity),
  .softDisable(softDisable),
  .modEn      (modEn),
  .bitOut     (bitOut)
);

// File: tb/dsm_bit_driver_tb_top.sv
module dsm_bit_driver_tb_top;

  localparam int FULL = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] valueWord = '0;
  logic        polarity = 1'b0;
  logic        softDisable = 1'b0;
  logic        modEn = 1'b0;
  logic        bitOut;

  int   nChecks = 0;
  int   nFails = 0;
  int   modelRes = 0;
  logic modelOut = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  dsm_bit_driver dut_i (
    .clk(clk), .rst_n(rst_n), .valueWord(valueWord), .polarity(polarity),
    .softDisable(softDisable), .modEn(modEn), .bitOut(bitOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effOf();
    int c;
    c = int'(valueWord[15:6]);
    return polarity ? (FULL - 1 - c) : c;
  endfunction

  // Called at a falling edge with the inputs already set; compares the output at the next falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      modelRes = 0;
      modelOut = 1'b0;
    end else if (softDisable) begin
      modelOut = polarity;
    end else if (modEn) begin
      int s;
      s = modelRes + effOf();
      modelOut = (s >= FULL);
      modelRes = s % FULL;
    end
    @(negedge clk);
    check(tag, int'(bitOut), int'(modelOut));
  endtask

  task automatic window(input int code, input bit pol, input string tag, input bit jitterLow);
    int ones;
    ones = 0;
    polarity = pol;
    softDisable = 1'b0;
    modEn = 1'b1;
    for (int i = 0; i < FULL; i++) begin
      valueWord = {10'(code), jitterLow ? 6'(i * 7 + 3) : 6'd0};
      tick(tag);
      ones += int'(bitOut);
    end
    check(tag, ones, pol ? (FULL - 1 - code) : code);
  endtask

  task automatic burstRun(input int code, input string tag);
    int pairs;
    logic prev;
    pairs = 0;
    prev = 1'b0;
    polarity = 1'b0;
    softDisable = 1'b0;
    modEn = 1'b1;
    valueWord = {10'(code), 6'd0};
    for (int i = 0; i < FULL; i++) begin
      tick(tag);
      if (prev && bitOut) pairs++;
      prev = bitOut;
    end
    check(tag, pairs, 0);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      tick("R6");
      check("R6", int'(bitOut), 0);
    end
    rst_n = 1'b1;

    window(0, 1'b0, "R7", 1'b0);
    window(1023, 1'b1, "R7", 1'b0);
    window(613, 1'b0, "R1", 1'b1);
    window(200, 1'b1, "R1", 1'b1);

    for (int c = 0; c < FULL; c += 31) begin
      window(c, 1'b0, "R2", 1'b0);
      window(c, 1'b1, "R3", 1'b0);
    end
    window(512, 1'b0, "R2", 1'b0);
    window(1023, 1'b0, "R2", 1'b0);
    window(1, 1'b1, "R3", 1'b0);

    burstRun(511, "R8");
    burstRun(300, "R8");

    // R4: freeze mid-stream, check the static level, then resume from the held residue.
    valueWord = {10'd700, 6'd0};
    polarity = 1'b0;
    for (int i = 0; i < 5; i++) tick("R4");
    softDisable = 1'b1;
    polarity = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick("R4");
      check("R4", int'(bitOut), 1);
    end
    polarity = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick("R4");
      check("R4", int'(bitOut), 0);
    end
    softDisable = 1'b0;
    for (int i = 0; i < 12; i++) tick("R4");

    // R5: the enable low holds everything, even while the code changes.
    valueWord = {10'd333, 6'd0};
    for (int i = 0; i < 3; i++) tick("R5");
    modEn = 1'b0;
    for (int i = 0; i < 6; i++) begin
      valueWord = {10'(100 * i + 50), 6'd0};
      tick("R5");
    end
    modEn = 1'b1;
    for (int i = 0; i < 8; i++) tick("R5");

    // R9: a code change mid-stream keeps the residue.
    valueWord = {10'd200, 6'd0};
    for (int i = 0; i < 13; i++) tick("R9");
    valueWord = {10'd900, 6'd0};
    for (int i = 0; i < 40; i++) tick("R9");
    polarity = 1'b1;
    for (int i = 0; i < 20; i++) tick("R9");

    // R6: reset in the middle of a stream.
    rst_n = 1'b0;
    tick("R6");
    check("R6", int'(bitOut), 0);
    rst_n = 1'b1;
    polarity = 1'b0;
    for (int i = 0; i < 10; i++) tick("R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule